// File: doc/BRIEF.md
# Programmable Reloading Frequency Divider

This block divides its input clock by a programmable ratio using nothing but a single loadable down-counter whose terminal-count flag steers its own mode. While the count is non-zero the counter decrements; once it reaches zero, the active-low output asserts, the counter is switched into load mode, and the next clock edge reloads the program value. The output therefore gives one low cycle every `prog + 1` input clocks. With the default 4-bit width this covers ratios 1 through 16.

The program value is sampled only on reload edges. A new value written in the middle of a period leaves that period alone and takes effect from the next reload. Reset clears the count to zero. This is the terminal state, so the first clock edge after reset loads the program value and the output is low while reset is held.

Top module: `rdiv_top`

## Requirements
- R1: While `rst_n` is low the count is zero and `div_out_n` is low (0 = asserted).
- R2: The first rising clock edge after reset release loads `prog`. For `prog` = N ≥ 1, `div_out_n` is high after that edge and next goes low after edge N+1.
- R3: With a constant `prog` = N, `div_out_n` is low after release edge k exactly when k is a multiple of N+1. The period is N+1 clocks for every N from 0 to 2^CNT_W−1.
- R4: For `prog` ≥ 1, each low pulse on `div_out_n` lasts exactly one clock cycle.
- R5: With `prog` = 0, `div_out_n` stays low on every cycle, which is divide by one.
- R6: A change of `prog` in the middle of a period leaves the current period unchanged. The new value sets the period from the next reload onward.
- R7: The largest program value, 2^CNT_W−1, gives a period of 2^CNT_W clocks. The count wraps through no other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog | input | CNT_W | Program value N; the division ratio is N+1 |
| div_out_n | output | 1 | Divided output, active-low one-cycle pulse at terminal count |

## Verification
The bench sweeps every program value from 0 to 15. It predicts the output after each edge from the arithmetic rule (k mod (N+1)), which exposes a design that is off by one and divides by N or N+2. It also exposes a design that never reloads at the edges of the range: N = 0 must give a constant low, and N = 15 must not wrap early. A mid-period change of the program value catches a counter that samples its data input on every edge instead of only on reload, since that design would shorten or stretch the running period. The reset phase and the first edge after it catch a design that starts counting from zero instead of loading first, which would shift every pulse by one period.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  // Operation applied to the counter on the next clock edge.
  typedef enum logic {
    OP_LOAD = 1'b0,
    OP_DOWN = 1'b1
  } op_e;

  // Terminal count forces load; otherwise keep counting down.
  function automatic op_e op_select(input logic at_terminal);
    return at_terminal ? OP_LOAD : OP_DOWN;
  endfunction

endpackage

// File: rtl/rdiv_counter.sv
module rdiv_counter
  import rdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic [CNT_W-1:0] count_d;

  always_comb begin
    unique case (op)
      OP_LOAD: count_d = load_val;
      OP_DOWN: count_d = step_down(count_q);
      default: count_d = load_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/rdiv_term.sv
module rdiv_term #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count_q,
  output logic             term_hit
);

  function automatic logic is_zero(input logic [CNT_W-1:0] v);
    return (v == '0);
  endfunction

  assign term_hit = is_zero(count_q);

endmodule

// File: rtl/rdiv_select.sv
module rdiv_select
  import rdiv_pkg::*;
(
  input  logic term_hit,
  output op_e  op,
  output logic div_out_n
);

  // Carry-style output: low at terminal count and low whenever loading.
  assign op        = op_select(term_hit);
  assign div_out_n = !term_hit && (op != OP_LOAD);

endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prog,
  output logic             div_out_n
);

  logic [CNT_W-1:0] count_q;
  logic             term_hit;
  op_e              op;

  rdiv_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (prog),
    .count_q  (count_q)
  );

  rdiv_term #(.CNT_W(CNT_W)) u_term (
    .count_q  (count_q),
    .term_hit (term_hit)
  );

  rdiv_select u_select (
    .term_hit  (term_hit),
    .op        (op),
    .div_out_n (div_out_n)
  );

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] prog,
  input logic             div_out_n,
  input logic [CNT_W-1:0] count_q,
  input logic             term_hit
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_RELOAD_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> (count_q == $past(prog))); // R2

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !term_hit |=> (count_q == $past(count_q) - ONE)); // R3

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !div_out_n |=> (div_out_n || ($past(prog) == '0))); // R4

  AST_ZERO_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_out_n && prog == '0) |=> !div_out_n); // R5

  AST_HIGH_MEANS_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    div_out_n |=> (count_q < $past(count_q))); // R7

endmodule

bind rdiv_top rdiv_checker #(.CNT_W(CNT_W)) u_rdiv_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog      (prog),
  .div_out_n (div_out_n),
  .count_q   (count_q),
  .term_hit  (term_hit)
);

// File: tb/rdiv_top_bench.sv
`timescale 1ns/1ps
module rdiv_top_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] prog = '0;
  logic         div_out_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rdiv_top #(.CNT_W(W)) u_rdiv_top (
    .clk(clk), .rst_n(rst_n), .prog(prog), .div_out_n(div_out_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Hold reset a few cycles with program n, then release on a falling edge.
  task automatic restart(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    prog  = W'(n);
    repeat (3) begin
      @(negedge clk);
      check("R1", div_out_n, 1'b0);
    end
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    // R1: reset state
    restart(7);

    // R3 / R5 / R7 / R2: sweep every program value
    for (int n = 0; n < (1 << W); n++) begin
      int last_low;
      restart(n);
      check("R1", div_out_n, 1'b0);
      last_low = 0;
      for (int k = 1; k <= 3 * (n + 1); k++) begin
        logic exp;
        @(posedge clk); #1;
        exp = ((k % (n + 1)) == 0) ? 1'b0 : 1'b1;
        if (n == 0)           check("R5", div_out_n, exp);
        else if (k == 1)      check("R2", div_out_n, exp);
        else if (n == (1 << W) - 1) check("R7", div_out_n, exp);
        else                  check("R3", div_out_n, exp);
        if (div_out_n == 1'b0) begin
          if (n >= 1) begin
            check("R4", (k - last_low) == (n + 1), 1'b1);
          end
          last_low = k;
        end
      end
    end

    // R6: change program value mid-period (5 -> 2 after edge 3)
    restart(5);
    for (int k = 1; k <= 15; k++) begin
      logic exp;
      @(posedge clk); #1;
      exp = (k == 6 || k == 9 || k == 12 || k == 15) ? 1'b0 : 1'b1;
      check("R6", div_out_n, exp);
      if (k == 3) prog = W'(2);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule